// File: doc/BRIEF.md
# PCI Parity Generator and Error Reporter

This block creates the even parity bit for the PCI multiplexed address/data lines and the command/byte-enable lines, and it checks the parity bit that comes back on received phases. The parity bit is computed over all 36 covered lines, unused ones included. It is registered, so it appears one clock after the values it covers. It is put on the bus only in the clock after this agent drove AD. Parity generation is always on. Only the error reporting can be switched off.

On the clock after a phase, the received PAR is compared with the parity registered from that phase. A mismatch after an address phase is an address parity error. It is detected whatever the role inputs say. A mismatch after a data phase counts only when this agent is the master or the target. A data error drives the active-low data-error output, gated by its enable. An address error, or an escalated data error, produces a one-clock low pulse on the active-low system-error output, gated by its own enable. Both error outputs fall two clocks after the faulty phase. Two sticky bits record each kind of detected error even when reporting is disabled, and the caller clears them.

Top module: `pci_parity_guard`

## Requirements
- R1: In every cycle after reset, `par_o` equals the XOR of all 32 bits of `ad_i` and all 4 bits of `cbe_i` from the previous cycle, so that the 37 lines together hold an even number of ones. No enable affects this.
- R2: `par_oe_o` is 1 exactly in the cycle after a cycle with `drive_ad_i` = 1.
- R3: When `addr_phase_i` is 1 in cycle n, `par_i` in cycle n+1 differs from the expected parity, and `serr_en_i` is 1 in cycle n+1, `serr_n_o` is 0 in cycle n+2. This holds even when `is_master_i` and `is_target_i` are both 0.
- R4: When `data_phase_i` is 1 in cycle n with `is_master_i` or `is_target_i` at 1, `par_i` mismatches in cycle n+1, and `perr_en_i` is 1 in cycle n+1, `perr_n_o` is 0 in cycle n+2.
- R5: A data phase with both `is_master_i` and `is_target_i` at 0 raises no error output and sets no sticky bit, even when its parity mismatches.
- R6: With `perr_en_i` at 0, a data parity error leaves `perr_n_o` at 1, but `data_stat_o` still becomes 1 in cycle n+2.
- R7: A data parity error that drives `perr_n_o` low also drives `serr_n_o` low in the same cycle when `escalate_i` and `serr_en_i` are both 1. With `escalate_i` at 0 it does not.
- R8: With `serr_en_i` at 0, an address parity error leaves `serr_n_o` at 1, but `addr_stat_o` still becomes 1 in cycle n+2.
- R9: Each sticky bit stays at 1 until its clear bit is pulsed: `stat_clr_i[0]` clears `addr_stat_o` and `stat_clr_i[1]` clears `data_stat_o`. An error detected in the same cycle as a clear wins, and the bit stays at 1.
- R10: While reset is asserted and right after it, `perr_n_o` and `serr_n_o` are 1, and `par_oe_o`, `addr_stat_o` and `data_stat_o` are 0.
- R11: A matching `par_i` after an address or data phase raises no error output and sets no sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | 32 | Values on the address/data lines |
| cbe_i | input | 4 | Values on the command/byte-enable lines |
| addr_phase_i | input | 1 | Current cycle is an address phase |
| data_phase_i | input | 1 | Current cycle is a completed data phase |
| is_master_i | input | 1 | This agent is master of the transaction |
| is_target_i | input | 1 | This agent is target of the transaction |
| drive_ad_i | input | 1 | This agent drives AD in the current cycle |
| par_i | input | 1 | Parity bit received from the bus |
| perr_en_i | input | 1 | Enables reporting on perr_n_o |
| serr_en_i | input | 1 | Enables reporting on serr_n_o |
| escalate_i | input | 1 | Forwards reported data errors to serr_n_o |
| stat_clr_i | input | 2 | Clear pulses: bit 0 address sticky, bit 1 data sticky |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Drive enable for par_o |
| perr_n_o | output | 1 | Data parity error, active low |
| serr_n_o | output | 1 | System error, active low |
| addr_stat_o | output | 1 | Sticky: address parity error seen |
| data_stat_o | output | 1 | Sticky: data parity error seen |

## Verification
A stale or mis-registered phase flag shows up as an error output at the wrong cycle offset, or as an error on a cycle with no phase. The bench samples the outputs exactly two clocks after each phase to catch either case. A wrong parity register is visible on `par_o` one clock after any input pattern. A broken sticky path shows up at the status outputs in the same cycle as the error pulse, or as a bit that drops before its clear.

// File: rtl/pci_parity_guard.sv
module pci_parity_guard #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             addr_phase_i,
  input  logic             data_phase_i,
  input  logic             is_master_i,
  input  logic             is_target_i,
  input  logic             drive_ad_i,
  input  logic             par_i,
  input  logic             perr_en_i,
  input  logic             serr_en_i,
  input  logic             escalate_i,
  input  logic [1:0]       stat_clr_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_n_o,
  output logic             serr_n_o,
  output logic             addr_stat_o,
  output logic             data_stat_o
);
  logic par_q, addr_q, data_q, oe_q;
  logic perr_q, serr_q, astat_q, dstat_q;

  wire mismatch = par_i ^ par_q;
  wire addr_err = addr_q & mismatch;
  wire data_err = data_q & mismatch;
  wire data_rep = data_err & perr_en_i;

  always_ff @(posedge clk)
    par_q <= ^{ad_i, cbe_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= 1'b0;
      data_q  <= 1'b0;
      oe_q    <= 1'b0;
      perr_q  <= 1'b0;
      serr_q  <= 1'b0;
      astat_q <= 1'b0;
      dstat_q <= 1'b0;
    end else begin
      addr_q  <= addr_phase_i;
      data_q  <= data_phase_i & (is_master_i | is_target_i);
      oe_q    <= drive_ad_i;
      perr_q  <= data_rep;
      serr_q  <= serr_en_i & (addr_err | (data_rep & escalate_i));
      astat_q <= (astat_q & ~stat_clr_i[0]) | addr_err;
      dstat_q <= (dstat_q & ~stat_clr_i[1]) | data_err;
    end
  end

  assign par_o       = par_q;
  assign par_oe_o    = oe_q;
  assign perr_n_o    = ~perr_q;
  assign serr_n_o    = ~serr_q;
  assign addr_stat_o = astat_q;
  assign data_stat_o = dstat_q;
endmodule

module pci_parity_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ad_i,
  input logic [3:0]  cbe_i,
  input logic        drive_ad_i,
  input logic        perr_en_i,
  input logic        serr_en_i,
  input logic [1:0]  stat_clr_i,
  input logic        par_o,
  input logic        par_oe_o,
  input logic        perr_n_o,
  input logic        serr_n_o,
  input logic        addr_stat_o,
  input logic        data_stat_o
);
  p_par_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> par_o == $past(^{ad_i, cbe_i}));
  p_oe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> par_oe_o == $past(drive_ad_i));
  p_perr_has_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> data_stat_o);
  p_perr_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !perr_n_o) |-> $past(perr_en_i));
  p_serr_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !serr_n_o) |-> $past(serr_en_i));
  p_astat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(addr_stat_o)) |-> $past(stat_clr_i[0]));
  p_dstat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(data_stat_o)) |-> $past(stat_clr_i[1]));
  always_comb if (!rst_n) p_reset_idle_r10: assert (perr_n_o && serr_n_o && !par_oe_o);
endmodule

bind pci_parity_guard pci_parity_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .drive_ad_i(drive_ad_i),
  .perr_en_i(perr_en_i), .serr_en_i(serr_en_i), .stat_clr_i(stat_clr_i),
  .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o), .serr_n_o(serr_n_o),
  .addr_stat_o(addr_stat_o), .data_stat_o(data_stat_o));

// File: tb/pci_parity_guard_test.sv
module pci_parity_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0] cbe = '0;
  logic ap = 0, dp = 0, m = 0, t = 0, drv = 0, par = 0, pe = 0, se = 0, esc = 0;
  logic [1:0] clr = '0;
  logic par_o, par_oe, perr_n, serr_n, astat, dstat;
  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  pci_parity_guard uut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe), .addr_phase_i(ap),
    .data_phase_i(dp), .is_master_i(m), .is_target_i(t), .drive_ad_i(drv),
    .par_i(par), .perr_en_i(pe), .serr_en_i(se), .escalate_i(esc),
    .stat_clr_i(clr), .par_o(par_o), .par_oe_o(par_oe), .perr_n_o(perr_n),
    .serr_n_o(serr_n), .addr_stat_o(astat), .data_stat_o(dstat));

  typedef struct packed {
    logic [31:0] ad; logic [3:0] cbe;
    logic a, d, m, t, drv, flip, pe, se, esc, xperr, xserr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 4'h7, 1,0,0,0,0,1,0,1,0, 0,1},
    '{32'hDEAD_BEEF, 4'h6, 1,0,0,0,0,0,1,1,1, 0,0},
    '{32'h0000_0001, 4'h0, 0,1,0,1,0,1,1,0,0, 1,0},
    '{32'hA5A5_0F0F, 4'hC, 0,1,1,0,1,1,1,0,0, 1,0},
    '{32'hFFFF_0000, 4'h1, 0,1,0,0,0,1,1,1,1, 0,0},
    '{32'h8000_0003, 4'hE, 0,1,0,1,0,1,0,1,1, 0,0},
    '{32'h7777_7777, 4'h3, 0,1,0,1,0,1,1,1,1, 1,1},
    '{32'h0F0F_F0F0, 4'h9, 0,1,1,0,0,1,1,1,0, 1,0},
    '{32'h0000_00FF, 4'h2, 1,0,1,1,0,1,1,0,1, 0,0},
    '{32'h0000_0000, 4'h0, 1,0,0,0,1,0,1,1,0, 0,0},
    '{32'hFFFF_FFFF, 4'hF, 0,0,0,0,0,1,1,1,1, 0,0},
    '{32'h0000_0001, 4'h0, 0,1,1,0,1,0,1,1,1, 0,0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ap = 0; dp = 0; m = 0; t = 0; drv = 0; par = 0; clr = 2'b00;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic exp_par;
    repeat (3) @(negedge clk);
    check("R10 perr_n in reset", perr_n, 1);
    check("R10 serr_n in reset", serr_n, 1);
    check("R10 par_oe in reset", par_oe, 0);
    check("R10 stickies in reset", {astat, dstat}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", {perr_n, serr_n, par_oe, astat, dstat}, 5'b11000);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      ad = v.ad; cbe = v.cbe; ap = v.a; dp = v.d; m = v.m; t = v.t; drv = v.drv;
      pe = v.pe; se = v.se; esc = v.esc; par = 0;
      @(negedge clk);
      exp_par = ^{v.ad, v.cbe};
      check($sformatf("R1 par vec %0d", i), par_o, exp_par);
      check($sformatf("R2 oe vec %0d", i), par_oe, v.drv);
      idle(); ad = ~v.ad;
      par = exp_par ^ v.flip;
      @(negedge clk);
      check($sformatf("R3/R4/R5/R6/R7/R8/R11 perr vec %0d", i), perr_n, !v.xperr);
      check($sformatf("R3/R7/R8/R11 serr vec %0d", i), serr_n, !v.xserr);
      check($sformatf("R5/R8/R11 addr sticky vec %0d", i), astat, v.flip & v.a);
      check($sformatf("R5/R6/R11 data sticky vec %0d", i), dstat, v.flip & v.d & (v.m | v.t));
      par = 0; clr = 2'b11;
      @(negedge clk);
      check($sformatf("R3 serr single pulse vec %0d", i), serr_n, 1);
      clr = 2'b00;
      @(negedge clk);
    end

    // R9: hold and selective clear
    pe = 1; se = 1; esc = 0;
    ad = 32'h0000_0003; cbe = 4'h0; ap = 1;
    @(negedge clk);
    idle(); par = 1'b1;
    @(negedge clk);
    par = 0; ad = 0;
    repeat (5) @(negedge clk);
    check("R9 address sticky holds", astat, 1);
    clr = 2'b10;
    @(negedge clk);
    clr = 2'b00;
    @(negedge clk);
    check("R9 wrong clear bit ignored", astat, 1);
    clr = 2'b01;
    @(negedge clk);
    clr = 2'b00;
    check("R9 address sticky cleared", astat, 0);

    // R9: set wins over clear in the same cycle
    ad = 32'h0000_0010; cbe = 4'h0; dp = 1; t = 1;
    @(negedge clk);
    idle(); par = 1'b0; clr = 2'b10;
    @(negedge clk);
    idle();
    check("R9 set beats clear", dstat, 1);
    check("R4 perr with clear present", perr_n, 0);
    clr = 2'b10;
    @(negedge clk);
    clr = 2'b00;
    check("R9 data sticky cleared", dstat, 0);

    // R1: parity independent of enables with all enables off
    pe = 0; se = 0; esc = 0; ad = 32'h0000_0007; cbe = 4'h8;
    @(negedge clk);
    check("R1 par with enables off", par_o, 0);

    finish_run();
  end
endmodule